// File: doc/BRIEF.md
# Three-Decoder Instruction Steering Unit

This block sits between instruction-boundary marking and a set of three decoders: one complex decoder (lane 0) that turns a single instruction into one to four micro-ops, and two simple decoders (lanes 1 and 2) that each turn one instruction into exactly one micro-op. Every clock it looks at a window of up to three instructions, held in program order in slots 0 to 2. Each slot has a valid bit, a byte length and a micro-op class. The unit chooses how many leading instructions can be decoded this clock and which slot each decoder reads. It also raises a start strobe for the micro-sequencer when the oldest instruction cannot be handled by any decoder in one clock.

The window interface follows a valid/ready rule. The `take` count plays the part of ready: in each clock the upstream queue retires exactly the first `take` valid slots and presents the rest again, shifted down to slot 0, on the next clock. Only a contiguous run of valid slots starting at slot 0 is considered. When a window has one complex instruction, the window is rotated so that instruction lands on lane 0. When a window has two complex instructions, they are taken one per clock.

After a sequencer start the unit goes busy. It takes nothing until the sequencer reports completion on `seq_done`. The decoder lanes have no back-pressure: a lane that is flagged valid is decoded in that clock.

Top module: `insn_steer`

## Requirements
- R1: While `rst` is high, `take` is 0, `seq_start` is 0, `uop_cnt` is 0 and no `lane_vld` bit is set.
- R2: A valid slot is simple when its class is 1 and its length is at most 7 bytes. It is complex when its class is 2, 3 or 4 and its length is at most 7. It needs the sequencer when its class is 0, 5, 6 or 7, or when its length is 8 or more.
- R3: When every taken instruction is simple, lane d reads slot d (identity mapping). `take` equals the number of leading valid simple slots, up to 3.
- R4: When the taken instructions include one complex instruction in slot c, lane d reads slot (c+d) mod 3. A lane is valid only if the slot it reads is taken. Lane 0 therefore always carries the complex instruction.
- R5: A second complex instruction in the window is not taken in the same clock. `take` stops at its slot index.
- R6: When slot 0 needs the sequencer, `seq_start` pulses, `take` is 1, no lane is valid and `uop_cnt` is 0. A sequencer-bound instruction in slot 1 or 2 ends the taken prefix before that slot.
- R7: `uop_cnt` is the sum of micro-ops of the taken instructions: the class value for each complex instruction and 1 for each simple one. It never exceeds 6.
- R8: From the clock after `seq_start` until `seq_done` has been sampled high, `take`, `uop_cnt` and `lane_vld` are 0 and `seq_start` stays low. Steering resumes in the clock after the one in which `seq_done` was high. `seq_done` while idle has no effect.
- R9: A slot that follows an invalid slot is never taken, whatever its contents.
- R10: Outside a sequencer start, the number of set `lane_vld` bits equals `take`. Lane select fields use slot numbers 0 to 2, two bits per lane, with lane d in bits [2d+1:2d].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | 3 | Valid bit per window slot; bit i is slot i |
| slot_len | input | 3*LEN_W | Byte length per slot; slot i in bits [LEN_W*i +: LEN_W] |
| slot_cls | input | 3*CLS_W | Micro-op class per slot; slot i in bits [CLS_W*i +: CLS_W] |
| seq_done | input | 1 | Sequencer has finished the current instruction |
| lane_vld | output | 3 | Decoder lane d receives an instruction this clock |
| lane_sel | output | 6 | Slot number read by each lane, 2 bits per lane |
| take | output | 2 | Number of leading slots consumed this clock |
| seq_start | output | 1 | One-clock strobe handing slot 0 to the sequencer |
| uop_cnt | output | SUM_W | Micro-ops produced by the decoders this clock |

## Verification
On every cycle the assertions check four things. Lane 0 is occupied whenever any lane is. The lane count matches `take`. The micro-op count stays within 6. A sequencer start is alone in its clock, is always followed by the busy state, and that state releases after `seq_done`. Only the bench scenarios show that the correct slot reaches each lane for every rotation, and that `take` stops at exactly the right instruction. They also show that completion resumes steering in the following clock and that `seq_done` is ignored while idle. For this, the bench sweeps all 343 combinations of seven instruction kinds over the three slots.

// File: rtl/insn_steer_pkg.sv
package insn_steer_pkg;
  localparam int NSLOT  = 3;
  localparam int SLOT_W = 2;

  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_SIMPLE = 2'd1,
    K_CPLX   = 2'd2,
    K_SEQ    = 2'd3
  } kind_e;
endpackage

// File: rtl/insn_classify.sv
module insn_classify
  import insn_steer_pkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int CLS_W     = 3,
  parameter int MAX_LEN   = 7,
  parameter int CPLX_UOPS = 4,
  localparam int UW       = $clog2(CPLX_UOPS + 1)
) (
  input  logic             vld,
  input  logic [LEN_W-1:0] len,
  input  logic [CLS_W-1:0] cls,
  output kind_e            kind,
  output logic [UW-1:0]    nuop
);
  logic fits;
  assign fits = (int'(len) <= MAX_LEN);

  always_comb begin
    kind = K_NONE;
    nuop = '0;
    if (vld) begin
      if (!fits || cls == '0 || int'(cls) > CPLX_UOPS) begin
        kind = K_SEQ;
      end else if (cls == CLS_W'(1)) begin
        kind = K_SIMPLE;
        nuop = UW'(1);
      end else begin
        kind = K_CPLX;
        nuop = UW'(cls);
      end
    end
  end
endmodule

// File: rtl/insn_pick.sv
module insn_pick
  import insn_steer_pkg::*;
#(
  parameter int UW    = 3,
  parameter int SUM_W = 3
) (
  input  kind_e                    kind [NSLOT],
  input  logic [UW-1:0]            nuop [NSLOT],
  output logic [1:0]               take,
  output logic                     seq_hit,
  output logic [NSLOT-1:0]         dvld,
  output logic [NSLOT*SLOT_W-1:0]  dsel,
  output logic [SUM_W-1:0]         sum
);
  logic [SLOT_W-1:0] cidx;

  // Walk the window in program order, stopping at the first slot that
  // cannot share this clock with the ones already taken.
  always_comb begin
    logic have_c;
    logic stop;
    take    = '0;
    seq_hit = 1'b0;
    cidx    = '0;
    sum     = '0;
    have_c  = 1'b0;
    stop    = 1'b0;
    if (kind[0] == K_SEQ) begin
      seq_hit = 1'b1;
      take    = 2'd1;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (!stop) begin
          case (kind[i])
            K_SIMPLE: begin
              take = take + 2'd1;
              sum  = sum + SUM_W'(nuop[i]);
            end
            K_CPLX: begin
              if (have_c) begin
                stop = 1'b1;
              end else begin
                have_c = 1'b1;
                cidx   = SLOT_W'(i);
                take   = take + 2'd1;
                sum    = sum + SUM_W'(nuop[i]);
              end
            end
            default: stop = 1'b1;
          endcase
        end
      end
    end
  end

  // Rotate so the complex slot (or slot 0) lands on lane 0.
  for (genvar d = 0; d < NSLOT; d++) begin : g_lane
    logic [SLOT_W:0] s;
    always_comb begin
      s = {1'b0, cidx} + (SLOT_W + 1)'(d);
      if (s >= (SLOT_W + 1)'(NSLOT)) s = s - (SLOT_W + 1)'(NSLOT);
      dvld[d] = !seq_hit && (s < {1'b0, take});
      dsel[d*SLOT_W +: SLOT_W] = s[SLOT_W-1:0];
    end
  end
endmodule

// File: rtl/insn_seq_ctl.sv
module insn_seq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (rst)        busy <= 1'b0;
    else if (start) busy <= 1'b1;
    else if (done)  busy <= 1'b0;
  end

  p_start_busy_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  p_done_release_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && done) |=> !busy);
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
endmodule

// File: rtl/insn_steer.sv
module insn_steer
  import insn_steer_pkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int CLS_W     = 3,
  parameter int MAX_LEN   = 7,
  parameter int CPLX_UOPS = 4,
  localparam int SUM_W    = $clog2(CPLX_UOPS + NSLOT)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSLOT-1:0]        slot_vld,
  input  logic [NSLOT*LEN_W-1:0]  slot_len,
  input  logic [NSLOT*CLS_W-1:0]  slot_cls,
  input  logic                    seq_done,
  output logic [NSLOT-1:0]        lane_vld,
  output logic [NSLOT*SLOT_W-1:0] lane_sel,
  output logic [1:0]              take,
  output logic                    seq_start,
  output logic [SUM_W-1:0]        uop_cnt
);
  localparam int UW = $clog2(CPLX_UOPS + 1);

  kind_e             kind [NSLOT];
  logic [UW-1:0]     nuop [NSLOT];
  logic [1:0]        p_take;
  logic              p_seq;
  logic [NSLOT-1:0]  p_vld;
  logic [NSLOT*SLOT_W-1:0] p_sel;
  logic [SUM_W-1:0]  p_sum;
  logic              busy;
  logic              live;

  for (genvar i = 0; i < NSLOT; i++) begin : g_cls
    insn_classify #(
      .LEN_W(LEN_W), .CLS_W(CLS_W), .MAX_LEN(MAX_LEN), .CPLX_UOPS(CPLX_UOPS)
    ) u_cls (
      .vld  (slot_vld[i]),
      .len  (slot_len[i*LEN_W +: LEN_W]),
      .cls  (slot_cls[i*CLS_W +: CLS_W]),
      .kind (kind[i]),
      .nuop (nuop[i])
    );
  end

  insn_pick #(.UW(UW), .SUM_W(SUM_W)) u_pick (
    .kind    (kind),
    .nuop    (nuop),
    .take    (p_take),
    .seq_hit (p_seq),
    .dvld    (p_vld),
    .dsel    (p_sel),
    .sum     (p_sum)
  );

  insn_seq_ctl u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (seq_start),
    .done  (seq_done),
    .busy  (busy)
  );

  assign live      = !rst && !busy;
  assign take      = live ? p_take : 2'd0;
  assign seq_start = live && p_seq;
  assign lane_vld  = live ? p_vld : '0;
  assign lane_sel  = live ? p_sel : '0;
  assign uop_cnt   = (live && !p_seq) ? p_sum : '0;

  p_lane0_first_r4: assert property (@(posedge clk) disable iff (rst)
    (lane_vld != '0) |-> lane_vld[0]);
  p_count_match_r10: assert property (@(posedge clk) disable iff (rst)
    !seq_start |-> ($countones(lane_vld) == int'(take)));
  p_uop_limit_r7: assert property (@(posedge clk) disable iff (rst)
    int'(uop_cnt) <= CPLX_UOPS + NSLOT - 1);
  p_seq_alone_r6: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> (lane_vld == '0 && take == 2'd1 && uop_cnt == '0));
  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (take == 2'd0 && lane_vld == '0 && !seq_start));
  p_one_start_r8: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !seq_start);
endmodule

// File: tb/tb_insn_steer.sv
module tb_insn_steer;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] slot_vld;
  logic [11:0] slot_len;
  logic [8:0] slot_cls;
  logic       seq_done;
  logic [2:0] lane_vld;
  logic [5:0] lane_sel;
  logic [1:0] take;
  logic       seq_start;
  logic [2:0] uop_cnt;

  int tests = 0;
  int fails = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  insn_steer dut (
    .clk(clk), .rst(rst), .slot_vld(slot_vld), .slot_len(slot_len),
    .slot_cls(slot_cls), .seq_done(seq_done), .lane_vld(lane_vld),
    .lane_sel(lane_sel), .take(take), .seq_start(seq_start), .uop_cnt(uop_cnt)
  );

  // kind codes: 0 empty, 1 simple, 2..4 complex with that many micro-ops,
  // 5 sequencer by class, 6 sequencer by length (class 1, length >= 8)
  task automatic drive(input int c0, input int c1, input int c2, input int salt);
    int c[3];
    c[0] = c0; c[1] = c1; c[2] = c2;
    for (int i = 0; i < 3; i++) begin
      slot_vld[i] = (c[i] != 0);
      slot_len[i*4 +: 4] = 4'(1 + ((salt + i) % 7));
      case (c[i])
        0: slot_cls[i*3 +: 3] = 3'(1 + (salt % 4));
        5: slot_cls[i*3 +: 3] = ((salt + i) % 4 == 0) ? 3'd0 : 3'(4 + ((salt + i) % 4));
        6: begin
          slot_cls[i*3 +: 3] = 3'd1;
          slot_len[i*4 +: 4] = 4'(8 + ((salt + i) % 8));
        end
        default: slot_cls[i*3 +: 3] = 3'(c[i]);
      endcase
    end
  endtask

  function automatic logic [14:0] model(input int c0, input int c1, input int c2);
    int c[3];
    int n, u, cx, nc;
    logic [2:0] v;
    logic [5:0] s;
    c[0] = c0; c[1] = c1; c[2] = c2;
    if (c[0] >= 5) return {2'd1, 1'b1, 3'd0, 3'd0, 6'd0};
    n = 0; u = 0; cx = 0; nc = 0;
    for (int i = 0; i < 3; i++) begin
      if (c[i] == 0 || c[i] >= 5) break;
      if (c[i] >= 2) begin
        if (nc != 0) break;
        nc = 1; cx = i;
      end
      n++;
      u += c[i];
    end
    v = '0; s = '0;
    for (int d = 0; d < 3; d++) begin
      int sl = (cx + d) % 3;
      if (sl < n) begin
        v[d] = 1'b1;
        s[d*2 +: 2] = 2'(sl);
      end
    end
    return {2'(n), 1'b0, 3'(u), v, s};
  endfunction

  function automatic logic [14:0] observed();
    logic [5:0] s;
    for (int d = 0; d < 3; d++) s[d*2 +: 2] = lane_vld[d] ? lane_sel[d*2 +: 2] : 2'd0;
    return {take, seq_start, uop_cnt, lane_vld, s};
  endfunction

  task automatic check(input string req, input logic [14:0] exp);
    logic [14:0] got;
    got = observed();
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got take=%0d seq=%0d uops=%0d vld=%b sel=%b, expected take=%0d seq=%0d uops=%0d vld=%b sel=%b",
               req, got[14:13], got[12], got[11:9], got[8:6], got[5:0],
               exp[14:13], exp[12], exp[11:9], exp[8:6], exp[5:0]);
    end
  endtask

  function automatic string tag_of(input int c0, input int c1, input int c2);
    int c[3];
    int nc;
    c[0] = c0; c[1] = c1; c[2] = c2;
    if (c[0] >= 5) return "R6 (R2)";
    nc = 0;
    for (int i = 0; i < 3; i++) begin
      if (c[i] == 0) return (i < 2 && c[i+1] != 0) ? "R9 (R7 R10)" : "R3 (R7 R10)";
      if (c[i] >= 5) return "R6 prefix (R2 R7)";
      if (c[i] >= 2) begin
        if (nc != 0) return "R5 (R7 R10)";
        nc = 1;
      end
    end
    return (nc != 0) ? "R4 (R2 R7 R10)" : "R3 (R2 R7 R10)";
  endfunction

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; seq_done = 1'b0;
    drive(1, 1, 1, 0);
    repeat (2) @(negedge clk);
    #2 check("R1 reset quiet", 15'd0);
    drive(5, 1, 1, 1);
    #2 check("R1 reset blocks sequencer start", 15'd0);
    @(negedge clk); rst = 1'b0;

    // seq_done while idle has no effect
    drive(1, 1, 1, 2); seq_done = 1'b1;
    #2 check("R8 idle seq_done ignored", model(1, 1, 1));
    @(negedge clk); seq_done = 1'b0;
    #2 check("R8 idle seq_done ignored next", model(1, 1, 1));

    for (int w = 0; w < 343; w++) begin
      int a, b, e;
      a = w / 49; b = (w / 7) % 7; e = w % 7;
      @(negedge clk);
      drive(a, b, e, w);
      #2 check(tag_of(a, b, e), model(a, b, e));
      if (a >= 5) begin
        @(negedge clk);
        #2 check("R8 busy after start", 15'd0);
        @(negedge clk);
        #2 check("R8 busy holds", 15'd0);
        seq_done = 1'b1;
        #1 check("R8 stalled while done", 15'd0);
        @(negedge clk);
        seq_done = 1'b0;
        drive(2, 1, 1, w);
        #2 check("R8 resume after done", model(2, 1, 1));
      end
    end

    // fixed corner windows
    @(negedge clk); drive(4, 1, 1, 3);
    #2 check("R7 six micro-ops", {2'd3, 1'b0, 3'd6, 3'b111, 2'd2, 2'd1, 2'd0});
    @(negedge clk); drive(1, 1, 3, 4);
    #2 check("R4 complex in slot 2", {2'd3, 1'b0, 3'd5, 3'b111, 2'd1, 2'd0, 2'd2});
    @(negedge clk); drive(1, 6, 1, 5);
    #2 check("R2 over-long slot stops prefix", {2'd1, 1'b0, 3'd1, 3'b001, 6'd0});

    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule